// File: doc/BRIEF.md
# Strided Buffer Sum and Maximum Scanner

This block keeps a buffer of unsigned samples in an internal register array that is loaded through a write port. On request it walks a fixed, strided subset of that buffer and returns the sum and the largest value of the samples it visits. The walk starts at entry 4 and visits every second entry up to entry 1022, which gives 510 samples with the default parameters. The block reads one sample per clock cycle through a registered read port. Each result register is a clocked flip-flop, so no result is produced by a combinational loop.

A pass starts when `start` is high while the block is idle and `buf_ready` is high. Both result registers are cleared on that edge. The pass then runs one sample per cycle for as long as `buf_ready` stays high. While `buf_ready` is low the scan freezes and both results hold their values. When the last sample has been added, `done` pulses for one cycle, and the results then hold until the next pass begins. A later stage can divide the sum to form an average.

Top module: `strided_scan_top`

## Requirements
- R1: `rst_n` is an active-low synchronous reset. On a clock edge where it is low, `sum_out` and `max_out` become 0, `done` becomes 0, `busy` becomes 0, and any pass in progress is abandoned.
- R2: A pass is accepted on a clock edge where `busy` is 0 and both `start` and `buf_ready` are 1. After that edge `busy` is 1 and `sum_out` and `max_out` are both 0, whatever the previous pass left in them.
- R3: A pass visits only the indices 4, 6, 8, … 1022, which is 510 samples. Indices 0 to 3, index 1023 and every odd index never affect either result.
- R4: `sum_out` is the unsigned sum of the visited samples. It is 20 bits wide and cannot wrap, even when all 510 samples hold 2047, which gives 1043970.
- R5: `max_out` is the largest visited sample, compared as an unsigned value. The stored maximum is replaced only by a sample that is strictly greater than it.
- R6: With `buf_ready` held high, a pass takes one sample per cycle. `done` is high for exactly one cycle, 511 cycles after the edge that accepted the pass, and on that cycle `busy` is already 0 and the final results are visible.
- R7: On a clock edge where `buf_ready` is low, neither `sum_out` nor `max_out` changes. The pass resumes when `buf_ready` returns high and gives the same final results.
- R8: A `start` that arrives while `busy` is 1 is ignored. The running pass is neither restarted nor cleared, and its `done` comes at the original time.
- R9: After `done`, `sum_out` and `max_out` hold their values and `done` stays low until another pass is accepted.
- R10: When `wr_en` is 1, `wr_data` is stored at entry `wr_addr` on the clock edge, and the next pass reads that entry's new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 10 | Buffer write index |
| wr_data | input | 11 | Sample written to the buffer |
| buf_ready | input | 1 | Buffer-ready enable; scan advances only while high |
| start | input | 1 | Request a new pass (taken only when idle) |
| sum_out | output | 20 | Sum of the visited samples |
| max_out | output | 11 | Largest visited sample |
| done | output | 1 | One-cycle pulse when the pass result is final |
| busy | output | 1 | A pass is in progress |

## Verification
Five buffer fillings are used, each with known expected results. An all-zero buffer and an all-full buffer pin down the clear and the no-wrap width. A buffer where each entry holds its own index shows the order of the walk and that each entry holds its own value. A buffer with every excluded entry set to 2047 and every visited entry set to 1 catches any stray offset or stride. A flat buffer with one peak tests the maximum on its own. Further directed runs stall the pass with a periodic `buf_ready` pattern, pulse `start` in the middle of a pass, hold the results after `done`, and reset in the middle of a scan. Together they separate a correct freeze, restart or clear from a wrong one.

// File: rtl/scan_pkg.sv
// Package: shared types for the strided buffer scanner.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package scan_pkg;

    // Control states of the scan sequencer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2
    } scan_state_t;

endpackage

// File: rtl/scan_mem.sv
// Module: sample buffer, a register array with one write port and one
// registered read port (a read has one cycle of latency).
// Assumes: the read and the write to the same entry in the same cycle return
// the old value; the contents are not reset.
module scan_mem #(
    parameter int DATA_W = 11,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Store one sample per write strobe
    always_ff @(posedge clk) begin
        if (wr_en)
            cells[wr_addr] <= wr_data;
    end

    // Register the addressed sample when a read is issued
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_data <= cells[rd_addr];
    end

endmodule

// File: rtl/scan_ctrl.sv
// Module: sequencer that accepts a pass, walks the strided index range and
// issues one read per advancing cycle, then drains the read pipeline.
// Assumes: advance is governed by buf_ready alone; start is taken only in idle.
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int START_IDX = 4,
    parameter int STRIDE    = 2,
    parameter int LAST_IDX  = 1022
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_ready,
    input  logic              start,
    output logic              clr,
    output logic              issue,
    output logic              issue_last,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              busy
);

    localparam logic [ADDR_W-1:0] FIRST_A = ADDR_W'(START_IDX);
    localparam logic [ADDR_W-1:0] LAST_A  = ADDR_W'(LAST_IDX);
    localparam logic [ADDR_W-1:0] STEP_A  = ADDR_W'(STRIDE);

    scan_state_t       state;
    logic [ADDR_W-1:0] idx;

    // Decode the accept, issue and last-issue strobes
    always_comb begin
        clr        = (state == ST_IDLE) && start && buf_ready;
        issue      = (state == ST_SCAN) && buf_ready;
        issue_last = issue && (idx == LAST_A);
        busy       = (state != ST_IDLE);
        rd_addr    = idx;
    end

    // Advance the state and the index one step per enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= FIRST_A;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (clr) begin
                        state <= ST_SCAN;
                        idx   <= FIRST_A;
                    end
                end
                ST_SCAN: begin
                    if (issue) begin
                        if (idx == LAST_A)
                            state <= ST_DRAIN;
                        else
                            idx <= idx + STEP_A;
                    end
                end
                ST_DRAIN: begin
                    if (buf_ready)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/scan_accum.sv
// Module: accumulate stage; adds each returned sample to a widened sum,
// keeps the strict unsigned maximum and pulses done after the last sample.
// Assumes: rd_data is valid one advancing cycle after the matching issue.
module scan_accum #(
    parameter int DATA_W = 11,
    parameter int SUM_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic              issue,
    input  logic              issue_last,
    input  logic [DATA_W-1:0] rd_data,
    output logic [SUM_W-1:0]  sum_q,
    output logic [DATA_W-1:0] max_q,
    output logic              done_q
);

    logic vld_q;
    logic last_q;

    // Track which read is in flight and fold the returned sample in
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            last_q <= 1'b0;
            sum_q  <= '0;
            max_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clr) begin
                vld_q  <= 1'b0;
                last_q <= 1'b0;
                sum_q  <= '0;
                max_q  <= '0;
            end else if (adv) begin
                vld_q  <= issue;
                last_q <= issue_last;
                if (vld_q) begin
                    sum_q <= sum_q + SUM_W'(rd_data);
                    if (rd_data > max_q)
                        max_q <= rd_data;
                    if (last_q)
                        done_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/strided_scan_top.sv
// Module: top of the strided buffer scanner; joins the sample buffer, the
// sequencer and the accumulate stage.
// Assumes: STRIDE >= 1 and START_IDX < DEPTH-1.
module strided_scan_top #(
    parameter int DATA_W    = 11,
    parameter int DEPTH     = 1024,
    parameter int START_IDX = 4,
    parameter int STRIDE    = 2,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int NSAMP    = (DEPTH - 2 - START_IDX) / STRIDE + 1,
    localparam int LAST_IDX = START_IDX + (NSAMP - 1) * STRIDE,
    localparam int SUM_W    = DATA_W + $clog2(NSAMP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              buf_ready,
    input  logic              start,
    output logic [SUM_W-1:0]  sum_out,
    output logic [DATA_W-1:0] max_out,
    output logic              done,
    output logic              busy
);

    logic              clr;
    logic              issue;
    logic              issue_last;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    scan_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (issue),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    scan_ctrl #(
        .ADDR_W    (ADDR_W),
        .START_IDX (START_IDX),
        .STRIDE    (STRIDE),
        .LAST_IDX  (LAST_IDX)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_ready  (buf_ready),
        .start      (start),
        .clr        (clr),
        .issue      (issue),
        .issue_last (issue_last),
        .rd_addr    (rd_addr),
        .busy       (busy)
    );

    scan_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .adv        (buf_ready),
        .issue      (issue),
        .issue_last (issue_last),
        .rd_data    (rd_data),
        .sum_q      (sum_out),
        .max_q      (max_out),
        .done_q     (done)
    );

endmodule

// File: rtl/strided_scan_checker.sv
// Module: property checker for the strided buffer scanner, bound to the top.
// Assumes: the same parameters as the top; reset is synchronous, active low.
module strided_scan_checker #(
    parameter int DATA_W    = 11,
    parameter int SUM_W     = 20,
    parameter int ADDR_W    = 10,
    parameter int START_IDX = 4,
    parameter int STRIDE    = 2,
    parameter int LAST_IDX  = 1022
) (
    input logic              clk,
    input logic              rst_n,
    input logic              buf_ready,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [SUM_W-1:0]  sum_out,
    input logic [DATA_W-1:0] max_out,
    input logic              issue,
    input logic [ADDR_W-1:0] rd_addr
);

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && buf_ready) |=> (busy && sum_out == '0 && max_out == '0)); // R2

    AST_ADDR_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (int'(rd_addr) >= START_IDX && int'(rd_addr) <= LAST_IDX
                   && ((int'(rd_addr) - START_IDX) % STRIDE) == 0)); // R3

    AST_SUM_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (sum_out >= $past(sum_out))); // R4

    AST_MAX_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (max_out >= $past(max_out))); // R5

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_ready |=> ($stable(sum_out) && $stable(max_out))); // R7

endmodule

bind strided_scan_top strided_scan_checker #(
    .DATA_W    (DATA_W),
    .SUM_W     (SUM_W),
    .ADDR_W    (ADDR_W),
    .START_IDX (START_IDX),
    .STRIDE    (STRIDE),
    .LAST_IDX  (LAST_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .buf_ready (buf_ready),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .sum_out   (sum_out),
    .max_out   (max_out),
    .issue     (issue),
    .rd_addr   (rd_addr)
);

// File: tb/strided_scan_top_tb.sv
`timescale 1ns/1ps
module strided_scan_top_tb;

    localparam int PASS_CYC = 511;
    localparam int LIMIT    = 5000;

    typedef struct packed {
        logic [2:0]  mode;
        logic [19:0] exp_sum;
        logic [10:0] exp_max;
    } vec_t;

    // mode 0: all zero, 1: all 2047, 2: entry = index,
    // 3: visited entries 1 / excluded 2047, 4: flat 5 with 1500 at index 600
    localparam vec_t VECS [5] = '{
        '{3'd0, 20'd0,       11'd0},
        '{3'd1, 20'd1043970, 11'd2047},
        '{3'd2, 20'd261630,  11'd1022},
        '{3'd3, 20'd510,     11'd1},
        '{3'd4, 20'd4045,    11'd1500}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [10:0] wr_data = '0;
    logic        buf_ready = 1'b0;
    logic        start = 1'b0;
    logic [19:0] sum_out;
    logic [10:0] max_out;
    logic        done;
    logic        busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    strided_scan_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .buf_ready(buf_ready), .start(start),
        .sum_out(sum_out), .max_out(max_out), .done(done), .busy(busy)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] fill_val(input logic [2:0] mode, input int i);
        logic picked;
        picked = (i >= 4) && (i <= 1022) && (i % 2 == 0);
        case (mode)
            3'd0: return 11'd0;
            3'd1: return 11'd2047;
            3'd2: return 11'(i);
            3'd3: return picked ? 11'd1 : 11'd2047;
            default: return (i == 600) ? 11'd1500 : 11'd5;
        endcase
    endfunction

    task automatic load(input logic [2:0] mode);
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 10'(i); wr_data = fill_val(mode, i);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Launch a pass with buf_ready high; returns cycles from accept to done
    task automatic run_pass(output int n);
        @(negedge clk);
        start = 1'b1; buf_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "busy after accept", busy, 1);
        chk("R2", "sum cleared", sum_out, 0);
        chk("R2", "max cleared", max_out, 0);
        n = 0;
        while (!done && n < LIMIT) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        logic [19:0] psum;
        logic [10:0] pmax;
        logic        plow;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "sum at reset", sum_out, 0);
        chk("R1", "max at reset", max_out, 0);
        chk("R1", "done at reset", done, 0);
        chk("R1", "busy at reset", busy, 0);

        // Table walk
        for (int v = 0; v < 5; v++) begin
            load(VECS[v].mode);
            run_pass(n);
            chk("R6", "cycles to done", n, PASS_CYC);
            chk("R6", "busy low with done", busy, 0);
            chk("R4", "sum", sum_out, VECS[v].exp_sum);
            chk("R5", "max", max_out, VECS[v].exp_max);
            if (VECS[v].mode == 3'd3) chk("R3", "excluded entries ignored", sum_out, 510);
            if (VECS[v].mode == 3'd2) chk("R10", "per-entry writes", max_out, 1022);
            @(negedge clk);
            chk("R6", "done one cycle", done, 0);
        end

        // R9: results hold after done, even with buf_ready toggling
        buf_ready = 1'b0;
        repeat (10) @(negedge clk);
        buf_ready = 1'b1;
        repeat (10) @(negedge clk);
        chk("R9", "sum held", sum_out, 4045);
        chk("R9", "max held", max_out, 1500);
        chk("R9", "done stays low", done, 0);

        // R10: overwrite one visited entry and rescan
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 10'd10; wr_data = 11'd1800;
        @(negedge clk);
        wr_en = 1'b0;
        run_pass(n);
        chk("R10", "rewritten entry sum", sum_out, 4045 - 5 + 1800);
        chk("R10", "rewritten entry max", max_out, 1800);
        wr_en = 1'b1; wr_addr = 10'd10; wr_data = 11'd5;
        @(negedge clk);
        wr_en = 1'b0;

        // R7: stall pattern, low one cycle in three
        @(negedge clk);
        start = 1'b1; buf_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        plow = 1'b0; psum = sum_out; pmax = max_out;
        n = 0;
        while (!done && n < LIMIT) begin
            if (plow && n < 60) begin
                chk("R7", "sum frozen", sum_out, psum);
                chk("R7", "max frozen", max_out, pmax);
            end
            psum = sum_out; pmax = max_out;
            plow = (n % 3 == 0);
            buf_ready = !plow;
            @(negedge clk);
            n++;
        end
        buf_ready = 1'b1;
        chk("R7", "stalled pass done", done, 1);
        chk("R7", "stalled pass sum", sum_out, 4045);
        chk("R7", "stalled pass max", max_out, 1500);

        // R8: start pulse mid-pass ignored
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < LIMIT) begin
            if (n == 100) start = 1'b1;
            if (n == 101) start = 1'b0;
            @(negedge clk);
            n++;
        end
        chk("R8", "done time unchanged", n, PASS_CYC);
        chk("R8", "sum unchanged", sum_out, 4045);

        // R1: reset in the middle of a pass
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "busy after mid reset", busy, 0);
        chk("R1", "sum after mid reset", sum_out, 0);
        chk("R1", "max after mid reset", max_out, 0);
        repeat (600) @(negedge clk);
        chk("R1", "no done after abandon", done, 0);
        chk("R1", "sum stays zero", sum_out, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule